// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block is a small machine-level performance monitor for a core with a 32-bit register interface. It keeps a free-running cycle counter, a retired-instruction counter and a set of programmable event counters. Each counter is wider than one register word: 40 bits by default. Each programmable counter has its own event-select register. That register holds a bit mask over a group of single-cycle event strobes, such as instruction-cache misses. While the mask is zero, the counter stays idle.

Software reaches every counter through a simple register port that combines a write strobe with a combinational read. Each counter shows as two words. The low word holds the bottom 32 bits. The high word holds the remaining upper bits, right-aligned, with zeros above them. A carry out of the low word reaches the high word on the same clock edge. This makes the usual sampling sequence (read high, read low, read high again, retry on mismatch) reliable. Software can restart a counter at any time by writing zero to it.

Address map: counter k (0 = cycles, 1 = retired instructions, 2 and up = programmable) has its low word at address 2k and its high word at 2k+1. The event-select register of programmable counter j sits at address 2·(number of counters)+j. With the defaults that gives addresses 0–7 for the counters and 8–9 for the selects.

Top module: `perf_counter_bank`

## Requirements
- R1: A synchronous active-high reset clears every counter and every event-select register to zero.
- R2: The cycle counter (addresses 0/1) adds one on every clock edge that carries no write to it, starting right after reset with no configuration.
- R3: The retired-instruction counter (addresses 2/3) adds one on each edge where the retire strobe is high, and holds otherwise.
- R4: A programmable counter holds while its select is zero. Otherwise it adds exactly one on each edge where at least one event strobe whose bit is set in its select is high, whatever the number of such strobes. Strobes outside the mask have no effect.
- R5: A low-word read returns counter bits 31:0. A high-word read returns bits 39:32 in rdata[7:0], with rdata[31:8] zero and never a copy of the low word. Unmapped addresses (10–15) read as zero.
- R6: When a counter increments from a low word of all ones, the low word becomes zero and the high word rises by one on the same edge.
- R7: A write to a low address replaces only bits 31:0. A write to a high address replaces only bits 39:32, taken from wdata[7:0].
- R8: When a write and an increment hit the same counter on one edge, the counter takes the written value and does not increment on that edge.
- R9: A counter at all ones wraps to zero on its next increment, with no other effect.
- R10: An event-select register stores wdata[3:0] on a write to its address. It reads back zero-extended, with bit i enabling event strobe i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Instruction-retired strobe |
| event_i | input | 4 | Single-cycle event strobes |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |

## Verification
The bench uses the default parameters: 40-bit counters, 32-bit words, two programmable counters and four event strobes. With an 8-bit high field, the bench can preload a counter to one step below a carry or wrap using only two writes, so the carry and wraparound edges are reached in a few cycles. Four strobes let it apply masks where masked and unmasked events fire together, or where two masked events fire in the same cycle. Two programmable counters let it confirm that one select register does not affect its neighbour.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   localparam int unsigned IDX_CYCLE     = 0;
   localparam int unsigned IDX_RETIRE    = 1;
   localparam int unsigned NUM_FIXED_CNT = 2;

   function automatic int unsigned word_lo_addr(input int unsigned idx);
      return 2 * idx;
   endfunction

   function automatic int unsigned word_hi_addr(input int unsigned idx);
      return 2 * idx + 1;
   endfunction

   function automatic int unsigned select_addr(input int unsigned num_cnt,
                                               input int unsigned j);
      return 2 * num_cnt + j;
   endfunction
endpackage

// File: rtl/pcb_event_match.sv
module pcb_event_match #(
   parameter int unsigned NUM_EVT = 4
) (
   input  logic [NUM_EVT-1:0] events,
   input  logic [NUM_EVT-1:0] mask,
   output logic               hit
);
   generate
      if (NUM_EVT == 1) begin : g_single
         assign hit = events[0] & mask[0];
      end else begin : g_multi
         logic [NUM_EVT-1:0] masked;
         assign masked = events & mask;
         assign hit    = |masked;
      end
   endgenerate
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
   parameter int unsigned CNT_W  = 40,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              inc,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt
);
   localparam int unsigned HI_W = CNT_W - WORD_W;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (wr_lo) begin
         cnt_q <= {cnt_q[CNT_W-1:WORD_W], wdata};
      end else if (wr_hi) begin
         cnt_q <= {wdata[HI_W-1:0], cnt_q[WORD_W-1:0]};
      end else if (inc) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt = cnt_q;

   // R8
   lo_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
      wr_lo |=> (cnt[WORD_W-1:0] == $past(wdata)));

   // R7
   hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_hi && !wr_lo) |=> ((cnt[CNT_W-1:WORD_W] == $past(wdata[HI_W-1:0]))
                             && (cnt[WORD_W-1:0] == $past(cnt[WORD_W-1:0]))));

   // R6
   carry_same_edge_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && !wr_lo && !wr_hi && (&cnt[WORD_W-1:0]) && !(&cnt[CNT_W-1:WORD_W]))
      |=> ((cnt[WORD_W-1:0] == '0)
           && (cnt[CNT_W-1:WORD_W] == $past(cnt[CNT_W-1:WORD_W]) + HI_W'(1))));

   // R9
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && !wr_lo && !wr_hi && (&cnt)) |=> (cnt == '0));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!inc && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: rtl/pcb_read_mux.sv
module pcb_read_mux #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned CNT_W   = 40,
   parameter int unsigned NUM_CNT = 4,
   parameter int unsigned NUM_SEL = 2,
   parameter int unsigned SEL_W   = 4,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnts,
   input  logic [NUM_SEL-1:0][SEL_W-1:0]  sels,
   output logic [WORD_W-1:0]              rdata
);
   import pcb_pkg::*;

   localparam int unsigned HI_W = CNT_W - WORD_W;

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (addr == ADDR_W'(word_lo_addr(k))) begin
            rdata = cnts[k][WORD_W-1:0];
         end
         if (addr == ADDR_W'(word_hi_addr(k))) begin
            rdata = {{(WORD_W-HI_W){1'b0}}, cnts[k][CNT_W-1:WORD_W]};
         end
      end
      for (int j = 0; j < NUM_SEL; j++) begin
         if (addr == ADDR_W'(select_addr(NUM_CNT, j))) begin
            rdata = {{(WORD_W-SEL_W){1'b0}}, sels[j]};
         end
      end
   end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned CNT_W    = 40,
   parameter int unsigned NUM_PROG = 2,
   parameter int unsigned NUM_EVT  = 4,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               retire_i,
   input  logic [NUM_EVT-1:0] event_i,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [WORD_W-1:0]  wdata,
   output logic [WORD_W-1:0]  rdata
);
   import pcb_pkg::*;

   localparam int unsigned NUM_CNT = NUM_FIXED_CNT + NUM_PROG;
   localparam int unsigned NUM_REG = 2 * NUM_CNT + NUM_PROG;
   localparam int unsigned HI_W    = CNT_W - WORD_W;

   generate
      if (CNT_W <= WORD_W || CNT_W > 2 * WORD_W) begin : g_bad_width
         $error("CNT_W must exceed WORD_W and fit in two words");
      end
      if (NUM_EVT < 1 || NUM_EVT > WORD_W) begin : g_bad_evt
         $error("NUM_EVT must lie between 1 and WORD_W");
      end
      if (NUM_PROG < 1) begin : g_bad_prog
         $error("NUM_PROG must be at least 1");
      end
      if (NUM_REG > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [NUM_CNT-1:0][CNT_W-1:0]   cnts;
   logic [NUM_PROG-1:0][NUM_EVT-1:0] sels;
   logic [NUM_CNT-1:0]              inc_vec;
   logic [NUM_PROG-1:0]             hit_vec;

   genvar gj;
   generate
      for (gj = 0; gj < NUM_PROG; gj++) begin : g_prog
         logic sel_we;
         assign sel_we = wr_en && (addr == ADDR_W'(select_addr(NUM_CNT, gj)));

         always_ff @(posedge clk) begin
            if (rst) begin
               sels[gj] <= '0;
            end else if (sel_we) begin
               sels[gj] <= wdata[NUM_EVT-1:0];
            end
         end

         pcb_event_match #(.NUM_EVT(NUM_EVT)) u_match (
            .events (event_i),
            .mask   (sels[gj]),
            .hit    (hit_vec[gj])
         );
      end
   endgenerate

   genvar gk;
   generate
      for (gk = 0; gk < NUM_CNT; gk++) begin : g_cnt
         logic wr_lo_k;
         logic wr_hi_k;
         assign wr_lo_k = wr_en && (addr == ADDR_W'(word_lo_addr(gk)));
         assign wr_hi_k = wr_en && (addr == ADDR_W'(word_hi_addr(gk)));

         if (gk == IDX_CYCLE) begin : g_inc_cycle
            assign inc_vec[gk] = 1'b1;
         end else if (gk == IDX_RETIRE) begin : g_inc_retire
            assign inc_vec[gk] = retire_i;
         end else begin : g_inc_event
            assign inc_vec[gk] = hit_vec[gk - NUM_FIXED_CNT];
         end

         pcb_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc_vec[gk]),
            .wr_lo (wr_lo_k),
            .wr_hi (wr_hi_k),
            .wdata (wdata),
            .cnt   (cnts[gk])
         );
      end
   endgenerate

   pcb_read_mux #(
      .WORD_W  (WORD_W),
      .CNT_W   (CNT_W),
      .NUM_CNT (NUM_CNT),
      .NUM_SEL (NUM_PROG),
      .SEL_W   (NUM_EVT),
      .ADDR_W  (ADDR_W)
   ) u_rmux (
      .addr  (addr),
      .cnts  (cnts),
      .sels  (sels),
      .rdata (rdata)
   );

   logic cyc_written;
   assign cyc_written = wr_en && ((addr == ADDR_W'(word_lo_addr(IDX_CYCLE)))
                               || (addr == ADDR_W'(word_hi_addr(IDX_CYCLE))));

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> ((cnts == '0) && (sels == '0)));

   // R2
   cycle_free_run_chk: assert property (@(posedge clk) disable iff (rst)
      !cyc_written |=> (cnts[IDX_CYCLE] == $past(cnts[IDX_CYCLE]) + CNT_W'(1)));

   // R3
   retire_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!retire_i && !wr_en) |=> $stable(cnts[IDX_RETIRE]));

   // R5
   hi_word_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (addr[0] && (addr < ADDR_W'(2 * NUM_CNT))) |-> (rdata[WORD_W-1:HI_W] == '0));
endmodule

// File: tb/perf_counter_bank_test.sv
`timescale 1ns/1ps
module perf_counter_bank_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        retire_i = 1'b0;
   logic [3:0]  event_i = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   perf_counter_bank uut (
      .clk(clk), .rst(rst), .retire_i(retire_i), .event_i(event_i),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_evt(input logic [3:0] v);
      @(negedge clk);
      event_i = v;
      @(negedge clk);
      event_i = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 2; a < 10; a++) begin
         rd(4'(a), d);
         check("R1 reset value", d, 32'h0);
      end
      rd(4'd1, d);
      check("R1 cycle high after reset", d, 32'h0);
   endtask

   task automatic t_cycle();
      logic [31:0] d;
      wr(4'd0, 32'h0);
      rd(4'd0, d);
      check("R2 cycle restart", d, 32'h0);
      repeat (5) @(negedge clk);
      rd(4'd0, d);
      check("R2 cycle after 5 edges", d, 32'd5);
   endtask

   task automatic t_cycle_carry();
      logic [31:0] d;
      wr(4'd1, 32'h5);
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, d);
      check("R6 cycle low preload", d, 32'hFFFF_FFFF);
      rd(4'd1, d);
      check("R6 cycle high preload", d, 32'h5);
      @(negedge clk);
      rd(4'd0, d);
      check("R6 cycle low wrapped", d, 32'h0);
      rd(4'd1, d);
      check("R6 R5 cycle high carried", d, 32'h6);
   endtask

   task automatic t_retire();
      logic [31:0] d;
      wr(4'd2, 32'h0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk) retire_i = 1'b1;
         @(negedge clk) retire_i = 1'b0;
         @(negedge clk);
      end
      rd(4'd2, d);
      check("R3 retire count", d, 32'd3);
      rd(4'd3, d);
      check("R3 retire high", d, 32'h0);
   endtask

   task automatic t_idle();
      logic [31:0] d;
      @(negedge clk) event_i = 4'hF;
      repeat (4) @(negedge clk);
      event_i = '0;
      rd(4'd4, d);
      check("R4 zero select idle", d, 32'h0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(4'd8, 32'h2);
      rd(4'd8, d);
      check("R10 select readback", d, 32'h2);
      pulse_evt(4'b0001);
      rd(4'd4, d);
      check("R4 unmasked event ignored", d, 32'd0);
      pulse_evt(4'b0010);
      rd(4'd4, d);
      check("R4 masked event counts", d, 32'd1);
      pulse_evt(4'b0011);
      rd(4'd4, d);
      check("R4 two strobes count once", d, 32'd2);
      rd(4'd6, d);
      check("R4 neighbour idle", d, 32'd0);
      wr(4'd9, 32'hFFFF_FFFF);
      rd(4'd9, d);
      check("R10 select width", d, 32'hF);
   endtask

   task automatic t_wrap();
      logic [31:0] d;
      wr(4'd7, 32'hFF);
      wr(4'd6, 32'hFFFF_FFFF);
      pulse_evt(4'b1000);
      rd(4'd6, d);
      check("R9 wrap low", d, 32'h0);
      rd(4'd7, d);
      check("R9 wrap high", d, 32'h0);
   endtask

   task automatic t_prog_carry();
      logic [31:0] d;
      wr(4'd5, 32'h12);
      wr(4'd4, 32'hFFFF_FFFF);
      pulse_evt(4'b0010);
      rd(4'd4, d);
      check("R6 event carry low", d, 32'h0);
      rd(4'd5, d);
      check("R6 event carry high", d, 32'h13);
   endtask

   task automatic t_partial();
      logic [31:0] d;
      wr(4'd5, 32'hFFFF_FFAB);
      rd(4'd5, d);
      check("R7 R5 high write field", d, 32'hAB);
      rd(4'd4, d);
      check("R7 low kept on high write", d, 32'h0);
      wr(4'd4, 32'h7);
      rd(4'd5, d);
      check("R7 high kept on low write", d, 32'hAB);
      rd(4'd4, d);
      check("R7 low written", d, 32'h7);
      rd(4'd12, d);
      check("R5 unmapped reads zero", d, 32'h0);
   endtask

   task automatic t_write_wins();
      logic [31:0] d;
      @(negedge clk) event_i = 4'b0010;
      wr(4'd4, 32'd100);
      rd(4'd4, d);
      check("R8 low write beats event", d, 32'd100);
      @(negedge clk);
      rd(4'd4, d);
      check("R8 counting resumes", d, 32'd101);
      wr(4'd5, 32'h33);
      rd(4'd4, d);
      check("R8 no increment on high write", d, 32'd102);
      rd(4'd5, d);
      check("R8 high write value", d, 32'h33);
      event_i = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_cycle();
      t_cycle_carry();
      t_retire();
      t_idle();
      t_mask();
      t_wrap();
      t_prog_carry();
      t_partial();
      t_write_wins();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule